// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block is a bus master that runs single read and write cycles to asynchronous devices such as static RAM, flash or memory-mapped data converters. Each cycle has three timed phases: setup, where chip enable, byte enables and address settle; strobe, where the read or write strobe is low; and hold, where the decoded signals stay put after the strobe rises. Reads and writes take their phase lengths from separate fields of one 32-bit timing register. A ready input can stretch the strobe. After a read, a programmable number of idle turnaround cycles keeps the read device and the next driver off the data bus at the same time.

The host side takes requests as a valid/ready stream. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the request is outstanding, `req_ready` stays low, and that is the only form of back-pressure. Completion is a one-cycle `rsp_valid` pulse with the read data. The response side cannot be stalled, so the host must accept it on that cycle. The device side has a tri-state data bus, split into output value, output enable and input.

Top module: `async_strobe_ctrl`

## Requirements
- R1: The timing register resets to 0xFFFFFF23. A write through `cfg_we` replaces the whole word on the next edge, and `cfg_rdata` shows the register. The fields are: write setup [31:28], write strobe [27:22], write hold low bits [21:20] with bit 2 in [3], read setup [19:16], turnaround [15:14], read strobe [13:8], memory type [7:4] (stored only), read hold [2:0].
- R2: Chip enable goes low for max(setup,1) cycles before the strobe. The setup value comes from [19:16] for reads and from [31:28] for writes. Address and byte enables (`mem_be_n` = inverted `req_be`) hold steady for the whole time chip enable is low. `mem_be_n` is all ones while idle.
- R3: With ready high, the strobe lasts max(strobe,1) cycles. `mem_re_n` is low for reads and `mem_we_n` is low for writes, never both, and never outside chip enable.
- R4: After the strobe, chip enable stays low for exactly the hold count, which may be 0. The count is [2:0] for reads and {[3],[21:20]} for writes.
- R5: Ready is sampled at the clock edge that begins the last strobe cycle. If the sample is low, the strobe grows one cycle at a time, and each added cycle samples ready again at its own start. Ready during earlier strobe cycles has no effect.
- R6: Read data is the value on `mem_dq_i` at the edge that ends the final strobe cycle. It is presented on `rsp_rdata` with `rsp_valid`.
- R7: `mem_oe_n` is low during every setup, strobe and hold cycle of a read, and high at all other times.
- R8: `mem_dq_oe` is high, with `mem_dq_o` equal to the request's write data, through every setup, strobe and hold cycle of a write, and low at all other times.
- R9: After a read, turnaround [15:14] idle cycles (chip enable high) come before completion. A write has none.
- R10: `rsp_valid` is high for exactly one cycle. That cycle directly follows the last hold or turnaround cycle, or the last strobe cycle when both counts are 0.
- R11: `req_ready` is high exactly when the controller is idle, including the `rsp_valid` cycle. It is low from the accepting edge until completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_be_n | output | DATA_W/8 | Byte enables, active low |
| mem_addr | output | ADDR_W | Device address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_rdy | input | 1 | Device ready |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus input value |

## Verification
The bench uses the default 20-bit address and 32-bit data widths. It reprograms the timing word between accesses so that setup and strobe fields sweep 0 to 3 and hold sweeps 0 to 7, in both directions. Read and write fields get mirrored values, so a swapped field changes a measured phase length. The small values put the zero-to-one clamp, zero hold, zero turnaround and the write-hold extension bit all within a short run. Separate accesses use the reset word, which has the longest strobe, and hold ready low through several strobe cycles, both short of and past the programmed length.

// File: rtl/asc_pkg.sv
package asc_pkg;

  localparam int unsigned TIMING_W = 32;
  localparam logic [TIMING_W-1:0] TIMING_RESET = 32'hFFFF_FF23;

  localparam int unsigned SETUP_W  = 4;
  localparam int unsigned STROBE_W = 6;
  localparam int unsigned HOLD_W   = 3;
  localparam int unsigned TURN_W   = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0]  wr_setup;
    logic [STROBE_W-1:0] wr_strobe;
    logic [HOLD_W-1:0]   wr_hold;
    logic [SETUP_W-1:0]  rd_setup;
    logic [STROBE_W-1:0] rd_strobe;
    logic [HOLD_W-1:0]   rd_hold;
    logic [TURN_W-1:0]   turn;
  } timing_t;

endpackage

// File: rtl/asc_timing_reg.sv
module asc_timing_reg
  import asc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [TIMING_W-1:0] wdata,
  output logic [TIMING_W-1:0] rdata,
  output timing_t             fields
);

  logic [TIMING_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= TIMING_RESET;
    else if (we) word_q <= wdata;
  end

  assign rdata = word_q;

  // Field slicing; positions are fixed by the register layout.
  always_comb begin
    fields.wr_setup  = word_q[31:28];
    fields.wr_strobe = word_q[27:22];
    fields.wr_hold   = {word_q[3], word_q[21:20]};
    fields.rd_setup  = word_q[19:16];
    fields.turn      = word_q[15:14];
    fields.rd_strobe = word_q[13:8];
    fields.rd_hold   = word_q[2:0];
  end

endmodule

// File: rtl/asc_sequencer.sv
module asc_sequencer
  import asc_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    is_write,
  input  timing_t tcfg,
  input  logic    rdy,
  output phase_e  phase,
  output logic    done,
  output logic    capture
);

  phase_e             phase_q;
  logic [CNT_W-1:0]   rem_q;
  logic [CNT_W-1:0]   strobe_len_q;
  logic [CNT_W-1:0]   hold_len_q;
  logic [CNT_W-1:0]   turn_len_q;
  logic               wr_q;
  logic               rdy_q;
  logic               done_q;

  logic [CNT_W-1:0] setup_sel, strobe_sel, hold_sel;
  logic             last_cycle;

  always_comb begin
    setup_sel  = is_write ? CNT_W'(tcfg.wr_setup)  : CNT_W'(tcfg.rd_setup);
    strobe_sel = is_write ? CNT_W'(tcfg.wr_strobe) : CNT_W'(tcfg.rd_strobe);
    hold_sel   = is_write ? CNT_W'(tcfg.wr_hold)   : CNT_W'(tcfg.rd_hold);
    if (setup_sel == '0)  setup_sel  = CNT_W'(1);
    if (strobe_sel == '0) strobe_sel = CNT_W'(1);
  end

  assign last_cycle = (rem_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      rem_q        <= '0;
      strobe_len_q <= '0;
      hold_len_q   <= '0;
      turn_len_q   <= '0;
      wr_q         <= 1'b0;
      rdy_q        <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      rdy_q  <= rdy;
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q      <= PH_SETUP;
            rem_q        <= setup_sel;
            strobe_len_q <= strobe_sel;
            hold_len_q   <= hold_sel;
            turn_len_q   <= is_write ? '0 : CNT_W'(tcfg.turn);
            wr_q         <= is_write;
          end
        end
        PH_SETUP: begin
          if (!last_cycle) rem_q <= rem_q - 1'b1;
          else begin
            phase_q <= PH_STROBE;
            rem_q   <= strobe_len_q;
          end
        end
        PH_STROBE: begin
          if (!last_cycle) rem_q <= rem_q - 1'b1;
          else if (rdy_q) begin
            if (hold_len_q != '0) begin
              phase_q <= PH_HOLD;
              rem_q   <= hold_len_q;
            end else if (turn_len_q != '0) begin
              phase_q <= PH_TURN;
              rem_q   <= turn_len_q;
            end else begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (!last_cycle) rem_q <= rem_q - 1'b1;
          else if (turn_len_q != '0) begin
            phase_q <= PH_TURN;
            rem_q   <= turn_len_q;
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        PH_TURN: begin
          if (!last_cycle) rem_q <= rem_q - 1'b1;
          else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase   = phase_q;
  assign done    = done_q;
  assign capture = (phase_q == PH_STROBE) && last_cycle && rdy_q;

  // R5: a low ready sample at the start of the last strobe cycle keeps the strobe going
  assert_ready_extends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && last_cycle && !rdy_q) |=> (phase_q == PH_STROBE))
    else $error("strobe ended while ready sample was low");

  // R10: completion follows only from an active or turnaround phase
  assert_done_after_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(phase_q) != PH_IDLE))
    else $error("done raised without a finishing phase");

endmodule

// File: rtl/async_strobe_ctrl.sv
module async_strobe_ctrl
  import asc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [TIMING_W-1:0]   cfg_wdata,
  output logic [TIMING_W-1:0]   cfg_rdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_ce_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_oe_n,
  output logic                  mem_re_n,
  output logic                  mem_we_n,
  input  logic                  mem_rdy,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);

  localparam int unsigned BE_W = DATA_W / 8;

  timing_t           tcfg;
  phase_e            phase;
  logic              seq_done;
  logic              capture;
  logic              accept;
  logic              active;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              wr_q;
  logic [DATA_W-1:0] rdata_q;

  asc_timing_reg u_treg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .fields (tcfg)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  asc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .is_write (req_write),
    .tcfg     (tcfg),
    .rdy      (mem_rdy),
    .phase    (phase),
    .done     (seq_done),
    .capture  (capture)
  );

  // Request is held for the whole access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (capture && !wr_q) rdata_q <= mem_dq_i;
  end

  assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign mem_ce_n  = !active;
  assign mem_be_n  = active ? ~be_q : {BE_W{1'b1}};
  assign mem_addr  = addr_q;
  assign mem_oe_n  = !(active && !wr_q);
  assign mem_re_n  = !((phase == PH_STROBE) && !wr_q);
  assign mem_we_n  = !((phase == PH_STROBE) && wr_q);
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = active && wr_q;
  assign rsp_valid = seq_done;
  assign rsp_rdata = rdata_q;

  // R3: strobes only inside chip enable
  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !mem_ce_n)
    else $error("strobe outside chip enable");

  // R3: never both strobes
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!mem_re_n, !mem_we_n}) <= 1)
    else $error("read and write strobe together");

  // R7 / R8: output enable and bus drive are exclusive
  assert_oe_not_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe)
    else $error("device and controller drive the bus together");

  // R8: bus driven only inside chip enable
  assert_drive_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n)
    else $error("bus driven outside an access");

  // R11: no new request while an access is running
  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready)
    else $error("ready high during an access");

  // R10: completion is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("completion longer than one cycle");

  // R2: address and byte enables steady while chip enable stays low
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)))
    else $error("address changed inside an access");

endmodule

// File: tb/tb_async_strobe_ctrl.sv
module tb_async_strobe_ctrl;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [BE_W-1:0]   req_be = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_ce_n;
  logic [BE_W-1:0]   mem_be_n;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_oe_n, mem_re_n, mem_we_n;
  logic              mem_rdy = 1'b1;
  logic [DATA_W-1:0] mem_dq_o;
  logic              mem_dq_oe;
  logic [DATA_W-1:0] mem_dq_i = 32'hDEAD_BEEF;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model of the timing word
  int m_ws, m_wst, m_wh, m_rs, m_rst, m_rh, m_ta;

  always #2.5 clk = ~clk;

  async_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n),
    .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_rdy(mem_rdy), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // R1: program the timing word and confirm it reads back
  task automatic set_cfg(input int ws, input int wst, input int wh, input int rs,
                         input int ta, input int rst, input int rh, input int mt);
    logic [31:0] w;
    w = {ws[3:0], wst[5:0], wh[1:0], rs[3:0], ta[1:0], rst[5:0], mt[3:0], wh[2], rh[2:0]};
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata === w, "R1 register write", cfg_rdata, w);
    m_ws = ws; m_wst = wst; m_wh = wh; m_rs = rs; m_ta = ta; m_rst = rst; m_rh = rh;
  endtask

  task automatic run_txn(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [BE_W-1:0] be, input int k_rdy, input int tag);
    int e_setup, e_strobe, e_hold, e_turn, p;
    int ns, nst, nh, nt;
    int bad_sig, bad_oe, bad_drv, bad_rdy, bad_str;
    bit got;
    logic [DATA_W-1:0] last;
    e_setup = at_least1(wr ? m_ws : m_rs);
    p       = at_least1(wr ? m_wst : m_rst);
    e_strobe = (k_rdy > 0 && k_rdy + 1 > p) ? k_rdy + 1 : p;
    e_hold  = wr ? m_wh : m_rh;
    e_turn  = wr ? 0 : m_ta;
    ns = 0; nst = 0; nh = 0; nt = 0;
    bad_sig = 0; bad_oe = 0; bad_drv = 0; bad_rdy = 0; bad_str = 0;
    got = 1'b0; last = '0;

    @(negedge clk);
    if (k_rdy > 0) mem_rdy = 1'b0;
    check(req_ready === 1'b1, "R11 ready while idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 400; g++) begin
      if (rsp_valid) begin got = 1'b1; break; end
      if (!mem_ce_n) begin
        if (mem_addr !== a || mem_be_n !== ~be) bad_sig++;
        if (mem_oe_n !== wr) bad_oe++;
        if (mem_dq_oe !== wr || (wr && mem_dq_o !== d)) bad_drv++;
        if (req_ready !== 1'b0) bad_rdy++;
        if (wr ? (mem_re_n !== 1'b1) : (mem_we_n !== 1'b1)) bad_str++;
        if (wr ? !mem_we_n : !mem_re_n) begin
          nst++;
          last = 32'hC0DE_0000 | (tag << 8) | nst;
          mem_dq_i = last;
          if (k_rdy > 0 && nst == k_rdy) mem_rdy = 1'b1;
        end else begin
          mem_dq_i = 32'hDEAD_BEEF;
          if (nst == 0) ns++; else nh++;
        end
      end else begin
        nt++;
        if (mem_dq_oe !== 1'b0 || mem_oe_n !== 1'b1 || mem_be_n !== '1) bad_drv++;
        if (req_ready !== 1'b0) bad_rdy++;
      end
      @(negedge clk);
    end
    mem_rdy = 1'b1;
    check(got, "R10 completion seen", got, 1);
    check(ns == e_setup, "R2 setup length", ns, e_setup);
    check(nst == e_strobe, k_rdy > 0 ? "R5 extended strobe length" : "R3 strobe length", nst, e_strobe);
    check(nh == e_hold, "R4 hold length", nh, e_hold);
    check(nt == e_turn, "R9 turnaround length", nt, e_turn);
    check(bad_sig == 0, "R2 address and byte enables", bad_sig, 0);
    check(bad_str == 0, "R3 wrong strobe", bad_str, 0);
    check(bad_oe == 0, "R7 output enable", bad_oe, 0);
    check(bad_drv == 0, "R8 bus drive", bad_drv, 0);
    check(bad_rdy == 0, "R11 busy ready", bad_rdy, 0);
    if (!wr) check(rsp_rdata === last, "R6 read data capture", rsp_rdata, last);
    check(req_ready === 1'b1, "R11 ready on completion cycle", req_ready, 1);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 single pulse", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value and idle outputs
    check(cfg_rdata === 32'hFFFF_FF23, "R1 reset value", cfg_rdata, 32'hFFFF_FF23);
    check(mem_ce_n === 1'b1 && mem_re_n === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1,
          "R7 idle controls high", {mem_ce_n, mem_re_n, mem_we_n, mem_oe_n}, 4'hF);
    check(mem_dq_oe === 1'b0, "R8 idle bus released", mem_dq_oe, 0);
    check(mem_be_n === '1, "R2 idle byte enables", mem_be_n, 4'hF);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R11 idle handshake", {rsp_valid, req_ready}, 2'b01);

    // reset timing: setup 15, strobe 63, hold 3, turnaround 3
    m_ws = 15; m_wst = 63; m_wh = 3; m_rs = 15; m_rst = 63; m_rh = 3; m_ta = 3;
    run_txn(1'b0, 20'h12345, 32'h0, 4'hF, 0, 1);
    run_txn(1'b1, 20'hABCDE, 32'h1234_5678, 4'h5, 0, 2);

    // sweep of small timing values in both directions
    for (int s = 0; s < 4; s++)
      for (int st = 0; st < 4; st++)
        for (int h = 0; h < 8; h++) begin
          set_cfg(3 - s, 3 - st, 7 - h, s, (s + h) % 4, st, h, (s + st) % 16);
          run_txn(1'b0, ADDR_W'(s * 64 + st * 8 + h), 32'h0, 4'(h + 1), 0, s * 32 + st * 8 + h);
          run_txn(1'b1, ADDR_W'(~(s * 64 + st * 8 + h)), 32'h5A00_0000 + (s << 8) + (st << 4) + h,
                  4'(15 - h), 0, 0);
        end

    // R5 ready stalls: short programmed strobe held past, long strobe not lengthened
    set_cfg(1, 2, 1, 2, 2, 2, 1, 2);
    run_txn(1'b0, 20'h00111, 32'h0, 4'hF, 5, 200);
    run_txn(1'b1, 20'h00222, 32'hFACE_0001, 4'h3, 4, 0);
    set_cfg(1, 4, 0, 1, 0, 4, 0, 2);
    run_txn(1'b0, 20'h00333, 32'h0, 4'hC, 1, 201);
    run_txn(1'b0, 20'h00444, 32'h0, 4'hF, 4, 202);
    set_cfg(0, 0, 0, 0, 1, 0, 0, 2);
    run_txn(1'b0, 20'h00555, 32'h0, 4'h1, 3, 203);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule